// File: doc/BRIEF.md
# Register-File AND Execute Stage

This block carries out one byte-wide logical AND between an internal 8-bit working register (W) and one byte held in a 4 KiB data memory. It accepts a 16-bit instruction word together with a start strobe. It then runs the operation over four fixed internal phases: decode, operand read, compute, write-back. The result is stored either in W or back into the memory byte it came from. The negative and zero flags are updated from the result.

The memory byte address is 12 bits wide. Eight of those bits come from the instruction. The upper four come from one of two places, picked per instruction. The first is a fixed split mapping, where the lower half of the 8-bit range falls in bank 0 and the upper half falls in bank 15. The second is an external 4-bit bank register. The bank register is sampled during decode. W can be preloaded through a dedicated load port while the stage is idle.

Top module: `andx_exec`

## Requirements
- R1: After synchronous active-high reset, W is 0x00, both flags are 0, busy and done are low, and neither memory strobe is active.
- R2: A word is executed only when bits [15:10] equal 6'b000101. Any other word is dropped after the decode phase: there is no memory strobe, no done pulse, and no change to W, to the flags or to memory.
- R3: The result is the bitwise AND of W and the memory byte that was read.
- R4: Bit 9 selects the destination. When it is 0, the result goes to W and memory is not written. When it is 1, the result is written to the memory byte that was read, and W keeps its value.
- R5: When bit 8 is 0, the address is {4'h0, f} for f in 0x00..0x7F and {4'hF, f} for f in 0x80..0xFF, where f is bits [7:0].
- R6: When bit 8 is 1, the address is {bank[3:0], f}.
- R7: Flag N takes bit 7 of the result and flag Z is 1 exactly when the result is zero. Both change only at the end of the write phase and hold their values at all other times.
- R8: A start taken while idle raises busy in the next cycle (Q1). The read strobe is high for exactly the second cycle (Q2). Done is high for exactly the fourth cycle (Q4), as is the write strobe when the destination is memory. The new W, flags and memory contents are visible in the following cycle.
- R9: A start pulse that arrives while the stage is busy is ignored.
- R10: The W load port writes W only while the stage is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 16 | Instruction word |
| bank | input | 4 | Bank register, sampled in Q1 |
| w_ld | input | 1 | Load W from `w_ld_data` when idle |
| w_ld_data | input | 8 | Value for W preload |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Read strobe (Q2) |
| mem_rd_data | input | 8 | Read data, combinational from `mem_addr` |
| mem_wr_en | output | 1 | Write strobe (Q4, destination memory) |
| mem_wr_data | output | 8 | Write data |
| w_out | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Completion pulse in Q4 |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of an instruction. The stray word points at a different memory byte and chooses the memory destination, so a stage that wrongly accepted it would visibly corrupt that byte or raise a second done pulse. The stimulus injects such a word during Q3 and checks both the target byte and the done count. The access-bank split is hit directly at f = 0x7F and f = 0x80. Random words mix all four destination/bank combinations with random W, bank and memory contents. Directed zero-result and top-bit results force each flag both ways.

// File: rtl/andx_pkg.sv
package andx_pkg;

    localparam int INSN_W  = 16;
    localparam int DATA_W  = 8;
    localparam int FADR_W  = 8;
    localparam int BANK_W  = 4;
    localparam int ADDR_W  = FADR_W + BANK_W;
    localparam int OPC_W   = 6;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int DST_BIT = 9;
    localparam int SEL_BIT = 8;

    localparam logic [OPC_W-1:0]  OPC_AND     = 6'b000101;
    localparam logic [BANK_W-1:0] ACC_LO_BANK = 4'h0;
    localparam logic [BANK_W-1:0] ACC_HI_BANK = 4'hF;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4
    } phase_e;

    typedef struct packed {
        logic              hit;
        logic              to_file;
        logic              via_bank;
        logic [FADR_W-1:0] fadr;
    } dec_t;

    typedef struct packed {
        logic neg;
        logic zero;
    } flags_t;

    function automatic dec_t decode_word(input logic [INSN_W-1:0] w);
        dec_t d;
        d.hit      = (w[INSN_W-1:OPC_LSB] == OPC_AND);
        d.to_file  = w[DST_BIT];
        d.via_bank = w[SEL_BIT];
        d.fadr     = w[FADR_W-1:0];
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] access_map(input logic [FADR_W-1:0] f);
        return f[FADR_W-1] ? {ACC_HI_BANK, f} : {ACC_LO_BANK, f};
    endfunction

    function automatic flags_t flags_of(input logic [DATA_W-1:0] r);
        flags_t fl;
        fl.neg  = r[DATA_W-1];
        fl.zero = (r == '0);
        return fl;
    endfunction

endpackage

// File: rtl/andx_decode.sv
module andx_decode
    import andx_pkg::*;
(
    input  logic [INSN_W-1:0] ir,
    output dec_t              dec
);
    always_comb dec = decode_word(ir);
endmodule

// File: rtl/andx_addr.sv
module andx_addr
    import andx_pkg::*;
(
    input  dec_t              dec,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        if (dec.via_bank) addr = {bank, dec.fadr};
        else              addr = access_map(dec.fadr);
    end
endmodule

// File: rtl/andx_alu.sv
module andx_alu
    import andx_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = a[i] & b[i];
    end
endmodule

// File: rtl/andx_seq.sv
module andx_seq
    import andx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   hit,
    output logic   accept,
    output phase_e phase
);
    phase_e nxt;

    assign accept = start && (phase == PH_IDLE);

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (accept) nxt = PH_Q1;
            PH_Q1:   nxt = hit ? PH_Q2 : PH_IDLE;
            PH_Q2:   nxt = PH_Q3;
            PH_Q3:   nxt = PH_Q4;
            PH_Q4:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/andx_exec.sv
module andx_exec
    import andx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [INSN_W-1:0] instr,
    input  logic [BANK_W-1:0] bank,
    input  logic              w_ld,
    input  logic [DATA_W-1:0] w_ld_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [DATA_W-1:0] w_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              busy,
    output logic              done
);
    phase_e            phase;
    logic              accept;
    logic [INSN_W-1:0] ir_q;
    dec_t              dec_c, dec_q;
    logic [ADDR_W-1:0] addr_c, addr_q;
    logic [DATA_W-1:0] opnd_q, and_c, res_q, w_q;
    flags_t            flg_pend, flg_q;

    andx_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .hit    (dec_c.hit),
        .accept (accept),
        .phase  (phase)
    );

    andx_decode u_dec (
        .ir  (ir_q),
        .dec (dec_c)
    );

    andx_addr u_addr (
        .dec  (dec_c),
        .bank (bank),
        .addr (addr_c)
    );

    andx_alu #(.WIDTH(DATA_W)) u_alu (
        .a (w_q),
        .b (opnd_q),
        .y (and_c)
    );

    // Q0/Q1: capture word, latch decoded fields and address
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            dec_q  <= '0;
            addr_q <= '0;
        end else begin
            if (accept) ir_q <= instr;
            if (phase == PH_Q1) begin
                dec_q  <= dec_c;
                addr_q <= addr_c;
            end
        end
    end

    // Q2 read, Q3 compute
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q   <= '0;
            res_q    <= '0;
            flg_pend <= '0;
        end else begin
            if (phase == PH_Q2) opnd_q <= mem_rd_data;
            if (phase == PH_Q3) begin
                res_q    <= and_c;
                flg_pend <= flags_of(and_c);
            end
        end
    end

    // Q4 commit; W preload only while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            w_q   <= '0;
            flg_q <= '0;
        end else begin
            if (phase == PH_IDLE && w_ld)
                w_q <= w_ld_data;
            else if (phase == PH_Q4 && !dec_q.to_file)
                w_q <= res_q;
            if (phase == PH_Q4)
                flg_q <= flg_pend;
        end
    end

    assign mem_addr    = addr_q;
    assign mem_rd_en   = (phase == PH_Q2);
    assign mem_wr_en   = (phase == PH_Q4) && dec_q.to_file;
    assign mem_wr_data = res_q;
    assign w_out       = w_q;
    assign flag_n      = flg_q.neg;
    assign flag_z      = flg_q.zero;
    assign busy        = (phase != PH_IDLE);
    assign done        = (phase == PH_Q4);
endmodule

// File: rtl/andx_exec_chk.sv
module andx_exec_chk
    import andx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic [DATA_W-1:0] w_out,
    input logic              flag_n,
    input logic              flag_z,
    input logic              busy,
    input logic              done
);
    assert_rd_single_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    assert_rd_then_done_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> ##1 done);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_rd_wr_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    assert_wr_in_done_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> done);

    assert_w_kept_on_file_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> $stable(w_out));

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable({flag_n, flag_z}));

    assert_flags_match_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> (flag_n == $past(mem_wr_data[DATA_W-1]))
                   && (flag_z == ($past(mem_wr_data) == '0)));

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind andx_exec andx_exec_chk chk_i (.*);

// File: tb/andx_exec_tb.sv
module andx_exec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 300;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] instr;
    logic [3:0]  bank;
    logic        w_ld;
    logic [7:0]  w_ld_data;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;
    logic [7:0]  w_out;
    logic        flag_n, flag_z, busy, done;

    logic [7:0]  mem [4096];
    logic        pl_en;
    logic [11:0] pl_addr;
    logic [7:0]  pl_data;

    int  n_vec = 0;
    int  n_bad = 0;
    int  n_done = 0;
    bit  finished = 0;
    logic [7:0] sh_w;
    logic       sh_n, sh_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    andx_exec dut_i (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .bank(bank),
        .w_ld(w_ld), .w_ld_data(w_ld_data),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .w_out(w_out), .flag_n(flag_n), .flag_z(flag_z),
        .busy(busy), .done(done)
    );

    assign mem_rd_data = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_wr_en)  mem[mem_addr] <= mem_wr_data;
        else if (pl_en) mem[pl_addr]  <= pl_data;
        if (done) n_done <= n_done + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_addr(input logic [15:0] w, input logic [3:0] b);
        if (w[8]) return {b, w[7:0]};
        return w[7] ? {4'hF, w[7:0]} : {4'h0, w[7:0]};
    endfunction

    task automatic preload(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic load_w(input logic [7:0] d);
        @(negedge clk);
        w_ld = 1'b1; w_ld_data = d;
        @(negedge clk);
        w_ld = 1'b0;
        sh_w = d;
        chk(w_out == d, "R10", "W preload", w_out, d);
    endtask

    // poke: inject a stray start during Q3 aimed at another byte
    task automatic run_and(input logic [15:0] w, input logic [3:0] b, input bit poke);
        logic [11:0] a, stray_a;
        logic [7:0]  old, res, stray_old;
        logic [15:0] stray;
        int          d0;
        string       areq;
        a    = exp_addr(w, b);
        areq = w[8] ? "R6" : "R5";
        old  = mem[a];
        res  = sh_w & old;
        stray   = {6'b000101, 2'b11, ~w[7:0]};
        stray_a = exp_addr(stray, b);
        stray_old = mem[stray_a];
        d0 = n_done;
        @(negedge clk);
        instr = w; bank = b; start = 1'b1;
        @(negedge clk);                       // Q1
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy in Q1", busy, 1);
        @(negedge clk);                       // Q2
        chk(mem_rd_en == 1'b1, "R8", "read strobe in Q2", mem_rd_en, 1);
        chk(mem_addr == a, areq, "operand address", mem_addr, a);
        @(negedge clk);                       // Q3
        if (poke) begin instr = stray; start = 1'b1; end
        @(negedge clk);                       // Q4
        start = 1'b0;
        chk(done == 1'b1, "R8", "done in Q4", done, 1);
        chk(mem_wr_en == w[9], "R4", "write strobe", mem_wr_en, w[9]);
        if (w[9]) chk(mem_wr_data == res, "R3", "write data", mem_wr_data, res);
        @(negedge clk);                       // results
        if (w[9]) begin
            chk(mem[a] == res, "R4", "memory result", mem[a], res);
            chk(w_out == sh_w, "R4", "W kept", w_out, sh_w);
        end else begin
            chk(w_out == res, "R3", "W result", w_out, res);
            chk(mem[a] == old, "R4", "memory kept", mem[a], old);
            sh_w = res;
        end
        sh_n = res[7];
        sh_z = (res == 8'h00);
        chk(flag_n == sh_n, "R7", "N flag", flag_n, sh_n);
        chk(flag_z == sh_z, "R7", "Z flag", flag_z, sh_z);
        chk(!busy, "R8", "idle after Q4", busy, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(n_done - d0 == 1, "R9", "done count with stray start", n_done - d0, 1);
            if (stray_a != a)
                chk(mem[stray_a] == stray_old, "R9", "stray target kept",
                    mem[stray_a], stray_old);
            chk(w_out == sh_w, "R9", "W after stray", w_out, sh_w);
        end
    endtask

    task automatic run_bad(input logic [15:0] w, input logic [3:0] b);
        logic [11:0] a;
        logic [7:0]  old;
        int          d0;
        a   = exp_addr(w, b);
        old = mem[a];
        d0  = n_done;
        @(negedge clk);
        instr = w; bank = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(!mem_rd_en && !mem_wr_en, "R2", "no strobe on foreign word",
                {mem_rd_en, mem_wr_en}, 0);
            @(negedge clk);
        end
        chk(n_done == d0, "R2", "no done on foreign word", n_done - d0, 0);
        chk(w_out == sh_w, "R2", "W kept on foreign word", w_out, sh_w);
        chk({flag_n, flag_z} == {sh_n, sh_z}, "R2", "flags kept on foreign word",
            {flag_n, flag_z}, {sh_n, sh_z});
        chk(mem[a] == old, "R2", "memory kept on foreign word", mem[a], old);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 0; instr = 0; bank = 0; w_ld = 0; w_ld_data = 0;
        pl_en = 0; pl_addr = 0; pl_data = 0;
        sh_w = 0; sh_n = 0; sh_z = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(w_out == 8'h00, "R1", "W at reset", w_out, 0);
        chk({flag_n, flag_z} == 2'b00, "R1", "flags at reset", {flag_n, flag_z}, 0);
        chk(!busy && !done, "R1", "busy/done at reset", {busy, done}, 0);
        chk(!mem_rd_en && !mem_wr_en, "R1", "strobes at reset", {mem_rd_en, mem_wr_en}, 0);
        // R10 preload is blocked during reset
        w_ld = 1'b1; w_ld_data = 8'h5A;
        @(negedge clk);
        w_ld = 1'b0;
        chk(w_out == 8'h00, "R1", "W held in reset", w_out, 0);
        rst = 1'b0;
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            pl_en = 1'b1; pl_addr = 12'(i); pl_data = 8'($urandom);
        end
        @(negedge clk);
        pl_en = 1'b0;

        // example: W=0x17, byte 0xC2, destination W
        load_w(8'h17);
        preload(12'h025, 8'hC2);
        run_and({6'b000101, 2'b00, 8'h25}, 4'h3, 0);
        chk(w_out == 8'h02, "R3", "example W", w_out, 8'h02);
        chk(mem[12'h025] == 8'hC2, "R4", "example byte", mem[12'h025], 8'hC2);
        // zero result to memory, then negative result to W
        load_w(8'h0F);
        preload(12'h3AA, 8'hF0);
        run_and({6'b000101, 2'b11, 8'hAA}, 4'h3, 0);
        load_w(8'hFF);
        preload(12'h0C1, 8'h81);
        run_and({6'b000101, 2'b01, 8'hC1}, 4'h0, 0);
        // access-bank split boundary
        load_w(8'hFF);
        preload(12'h07F, 8'h3C);
        preload(12'h57F, 8'h00);
        run_and({6'b000101, 2'b10, 8'h7F}, 4'h5, 0);
        preload(12'hF80, 8'h99);
        preload(12'h080, 8'h00);
        run_and({6'b000101, 2'b10, 8'h80}, 4'h0, 0);
        // R10: preload while busy has no effect
        @(negedge clk);
        instr = {6'b000101, 2'b10, 8'h10}; bank = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; w_ld = 1'b1; w_ld_data = ~sh_w;
        repeat (4) @(negedge clk);
        w_ld = 1'b0;
        chk(w_out == sh_w, "R10", "preload ignored while busy", w_out, sh_w);
        sh_n = flag_n; sh_z = flag_z;
        // foreign words
        run_bad(16'h0000, 4'h2);
        run_bad({6'b000100, 2'b11, 8'h44}, 4'h2);
        run_bad({6'b100101, 2'b01, 8'h99}, 4'h7);
        // stray start while busy
        run_and({6'b000101, 2'b11, 8'h31}, 4'h9, 1);
        // random
        for (int k = 0; k < N_RANDOM; k++) begin
            if ($urandom_range(0, 3) == 0) load_w(8'($urandom));
            if ($urandom_range(0, 9) == 0) begin
                w = 16'($urandom);
                if (w[15:10] == 6'b000101) w[15] = 1'b1;
                run_bad(w, 4'($urandom));
            end else begin
                w = {6'b000101, 10'($urandom)};
                run_and(w, 4'($urandom), ($urandom_range(0, 19) == 0));
            end
        end
        summary();
    end
endmodule